// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner collects a large set of level-sensitive interrupt sources and folds them into groups of eight. Each group owns one output line toward a parent interrupt controller. The line is high while at least one source in the group is both enabled and asserted. The number of groups is a parameter, and the default is 20 groups, or 160 sources.

Software controls the block through a simple synchronous register port. Four consecutive groups share one bank of 32-bit registers, and each group takes one byte lane of that bank. A set register turns enables on for every bit written as one. A clear register turns enables off in the same way. A status register reports the enabled pending sources. Both the set and the clear offsets read back the current enables. This lets a driver save the enable state and later restore it: it clears all bits, then sets the saved ones.

Top module: `irq_combiner`

## Requirements
- R1: After synchronous reset every enable bit is 0, every group output is low and the read data is 0.
- R2: A write to bank offset 0x0 sets each enable bit whose write data bit is 1. Bits written as 0 keep their value.
- R3: A write to bank offset 0x4 clears each enable bit whose write data bit is 1. Bits written as 0 keep their value.
- R4: Group n sits in the bank whose base address is 0x10 times (n/4), in byte lane n mod 4, which is data bits [8*(n mod 4)+7 : 8*(n mod 4)]. Bit s of that lane is global source 8*n+s.
- R5: A read of offset 0x0 or 0x4 returns the enable bits of the addressed bank. The read data is registered: it appears on the cycle after the address is presented.
- R6: A read of offset 0xC returns the source levels ANDed with their enables, for all 32 bit positions of the bank.
- R7: Group output n is the OR over its eight sources of (source AND enable), registered once. It stays high as long as such a source stays high, and drops one cycle after the last one falls or is disabled.
- R8: Offsets other than 0x0, 0x4 and 0xC read 0 and ignore writes. The same holds for banks beyond the last group. Byte lanes that belong to no existing group read 0 and ignore writes.
- R9: While the write enable is low, no enable bit changes, whatever the address and write data.
- R10: Software can save the enables by reading offset 0x0, clear them all through offset 0x4, and rewrite the saved value to offset 0x0. This brings back exactly the saved state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 8*NUM_GROUPS | Level interrupt sources, group n at bits [8n+7:8n] |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| grp_irq_o | output | NUM_GROUPS | One registered interrupt line per group |

## Verification
The bench builds the block with six groups. This gives one full bank and a second bank in which only two of the four byte lanes belong to real groups. With this setting the partial-lane write masking, the zero read-back of absent lanes and the out-of-range bank addresses all fall within a few directed accesses. A full group map is still used, so the bank-and-lane mapping can be checked on a group in the second bank.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int SRC_PER_GRP  = 8;
    localparam int GRP_PER_BANK = 4;
    localparam int BANK_W       = SRC_PER_GRP * GRP_PER_BANK;
    localparam int OFS_W        = 4;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_SET,
        RSEL_CLR,
        RSEL_STAT
    } rsel_e;

    function automatic rsel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        case (ofs)
            4'h0:    return RSEL_SET;
            4'h4:    return RSEL_CLR;
            4'hC:    return RSEL_STAT;
            default: return RSEL_NONE;
        endcase
    endfunction

    function automatic int bank_of(input int grp);
        return grp / GRP_PER_BANK;
    endfunction

    function automatic int lane_of(input int grp);
        return grp % GRP_PER_BANK;
    endfunction

endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8,
    parameter int BIDX_W    = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    output logic [NUM_BANKS-1:0] set_stb,
    output logic [NUM_BANKS-1:0] clr_stb,
    output logic [BIDX_W-1:0]    bank_idx,
    output rsel_e                sel,
    output logic                 hit
);

    always_comb begin
        bank_idx = addr[ADDR_W-1:OFS_W];
        sel      = decode_ofs(addr[OFS_W-1:0]);
        hit      = (int'(bank_idx) < NUM_BANKS);
        for (int b = 0; b < NUM_BANKS; b++) begin
            set_stb[b] = we && hit && (bank_idx == BIDX_W'(b)) && (sel == RSEL_SET);
            clr_stb[b] = we && hit && (bank_idx == BIDX_W'(b)) && (sel == RSEL_CLR);
        end
    end

endmodule

// File: rtl/irqc_group.sv
module irqc_group
    import irqc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   set_stb,
    input  logic                   clr_stb,
    input  logic [SRC_PER_GRP-1:0] wlane,
    input  logic [SRC_PER_GRP-1:0] src,
    output logic [SRC_PER_GRP-1:0] en,
    output logic [SRC_PER_GRP-1:0] pend,
    output logic                   irq
);

    logic [SRC_PER_GRP-1:0] en_next;

    always_comb begin
        en_next = en;
        if (set_stb) en_next = en | wlane;
        if (clr_stb) en_next = en_next & ~wlane;
        pend = src & en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= '0;
            irq <= 1'b0;
        end else begin
            en  <= en_next;
            irq <= |pend;
        end
    end

endmodule

// File: rtl/irqc_readmux.sv
module irqc_readmux
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = 160,
    parameter int NUM_BANKS = 5,
    parameter int BIDX_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] en_all,
    input  logic [NUM_SRC-1:0] pend_all,
    input  logic [BIDX_W-1:0]  bank_idx,
    input  rsel_e              sel,
    input  logic               hit,
    output logic [BANK_W-1:0]  rdata
);

    localparam int PAD_W = NUM_BANKS * BANK_W;

    logic [PAD_W-1:0]  en_pad;
    logic [PAD_W-1:0]  pend_pad;
    logic [BANK_W-1:0] rd_next;

    always_comb begin
        en_pad                 = '0;
        pend_pad               = '0;
        en_pad[NUM_SRC-1:0]    = en_all;
        pend_pad[NUM_SRC-1:0]  = pend_all;
        rd_next                = '0;
        if (hit) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_idx == BIDX_W'(b)) begin
                    case (sel)
                        RSEL_SET, RSEL_CLR: rd_next = en_pad[b*BANK_W +: BANK_W];
                        RSEL_STAT:          rd_next = pend_pad[b*BANK_W +: BANK_W];
                        default:            rd_next = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_next;
    end

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irqc_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] src_i,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic                              reg_we,
    input  logic [BANK_W-1:0]                 reg_wdata,
    output logic [BANK_W-1:0]                 reg_rdata,
    output logic [NUM_GROUPS-1:0]             grp_irq_o
);

    localparam int NUM_SRC   = NUM_GROUPS * SRC_PER_GRP;
    localparam int NUM_BANKS = (NUM_GROUPS + GRP_PER_BANK - 1) / GRP_PER_BANK;
    localparam int BIDX_W    = ADDR_W - OFS_W;

    logic [NUM_BANKS-1:0] set_stb;
    logic [NUM_BANKS-1:0] clr_stb;
    logic [BIDX_W-1:0]    bank_idx;
    rsel_e                sel;
    logic                 hit;
    logic [NUM_SRC-1:0]   en_all;
    logic [NUM_SRC-1:0]   pend_all;

    irqc_regdec #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .BIDX_W    (BIDX_W)
    ) u_dec (
        .addr     (reg_addr),
        .we       (reg_we),
        .set_stb  (set_stb),
        .clr_stb  (clr_stb),
        .bank_idx (bank_idx),
        .sel      (sel),
        .hit      (hit)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int BK = bank_of(g);
        localparam int LN = lane_of(g);
        irqc_group u_grp (
            .clk     (clk),
            .rst     (rst),
            .set_stb (set_stb[BK]),
            .clr_stb (clr_stb[BK]),
            .wlane   (reg_wdata[LN*SRC_PER_GRP +: SRC_PER_GRP]),
            .src     (src_i[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .en      (en_all[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .pend    (pend_all[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .irq     (grp_irq_o[g])
        );
    end

    irqc_readmux #(
        .NUM_SRC   (NUM_SRC),
        .NUM_BANKS (NUM_BANKS),
        .BIDX_W    (BIDX_W)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .en_all   (en_all),
        .pend_all (pend_all),
        .bank_idx (bank_idx),
        .sel      (sel),
        .hit      (hit),
        .rdata    (reg_rdata)
    );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8
) (
    input logic                              clk,
    input logic                              rst,
    input logic [NUM_GROUPS*SRC_PER_GRP-1:0] src_i,
    input logic [ADDR_W-1:0]                 reg_addr,
    input logic                              reg_we,
    input logic [BANK_W-1:0]                 reg_wdata,
    input logic [BANK_W-1:0]                 reg_rdata,
    input logic [NUM_GROUPS-1:0]             grp_irq_o,
    input logic [NUM_GROUPS*SRC_PER_GRP-1:0] en_all
);

    localparam int NUM_SRC = NUM_GROUPS * SRC_PER_GRP;

    // R1: reset clears enables, lines and read data
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (en_all == '0 && grp_irq_o == '0 && reg_rdata == '0));

    // R9: no enable change without a write
    a_r9_no_write_stable: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(en_all));

    // R8: an unused offset reads zero
    a_r8_unused_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[OFS_W-1:0] == 4'h8) |=> (reg_rdata == '0));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int BIT = i % BANK_W;
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'((i / BANK_W) * 16);
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'((i / BANK_W) * 16 + 4);

        // R2: write-one-to-set
        a_r2_set_bit: assert property (@(posedge clk) disable iff (rst)
            (reg_we && reg_addr == SET_A && reg_wdata[BIT]) |=> en_all[i]);

        // R3: write-one-to-clear
        a_r3_clr_bit: assert property (@(posedge clk) disable iff (rst)
            (reg_we && reg_addr == CLR_A && reg_wdata[BIT]) |=> !en_all[i]);
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_line
        // R7: registered OR of enabled pending sources
        a_r7_line_high: assert property (@(posedge clk) disable iff (rst)
            ((src_i[g*SRC_PER_GRP +: SRC_PER_GRP] & en_all[g*SRC_PER_GRP +: SRC_PER_GRP]) != '0)
            |=> grp_irq_o[g]);
        a_r7_line_low: assert property (@(posedge clk) disable iff (rst)
            ((src_i[g*SRC_PER_GRP +: SRC_PER_GRP] & en_all[g*SRC_PER_GRP +: SRC_PER_GRP]) == '0)
            |=> !grp_irq_o[g]);
    end

endmodule

bind irq_combiner irqc_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .grp_irq_o (grp_irq_o),
    .en_all    (en_all)
);

// File: tb/irq_combiner_bench.sv
module irq_combiner_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NG         = 6;
    localparam int AW         = 8;
    localparam int NS         = NG * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src = '0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NG-1:0] irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_irq_combiner (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src),
        .reg_addr  (addr),
        .reg_we    (we),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .grp_irq_o (irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b0;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic drive_src(input logic [NS-1:0] s);
        @(negedge clk);
        src = s;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(rdata, 32'h0, "R1 rdata");
        check(32'(irq), 32'h0, "R1 irq");
        reg_read(8'h00, d); check(d, 32'h0, "R1 bank0 enables");
        reg_read(8'h10, d); check(d, 32'h0, "R1 bank1 enables");
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        reg_write(8'h00, 32'h0000_0081);
        reg_read(8'h00, d); check(d, 32'h0000_0081, "R2 set");
        reg_write(8'h00, 32'h0000_0100);
        reg_read(8'h00, d); check(d, 32'h0000_0181, "R2 zeros keep");
        reg_write(8'h04, 32'h0000_0001);
        reg_read(8'h04, d); check(d, 32'h0000_0180, "R3 clear, R5 read at 0x4");
    endtask

    task automatic t_lines();
        drive_src(NS'(1) << 8);
        check(32'(irq), 32'h02, "R7 group1 line");
        drive_src((NS'(1) << 8) | (NS'(1) << 7));
        check(32'(irq), 32'h03, "R7 groups 0 and 1");
        repeat (4) @(negedge clk);
        check(32'(irq), 32'h03, "R7 level held");
        drive_src(NS'(1) << 9);
        check(32'(irq), 32'h00, "R7 disabled source ignored");
    endtask

    task automatic t_status();
        logic [31:0] d;
        drive_src({16'hFFFF, 32'hFFFF_FFFF});
        reg_read(8'h0C, d); check(d, 32'h0000_0180, "R6 bank0 status");
        reg_read(8'h1C, d); check(d, 32'h0, "R6 bank1 status");
        drive_src('0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        reg_write(8'h10, 32'h0000_8000);
        reg_read(8'h10, d); check(d, 32'h0000_8000, "R4 group5 lane");
        drive_src(NS'(1) << 47);
        check(32'(irq), 32'h20, "R4 global source 47 drives group5");
        reg_read(8'h1C, d); check(d, 32'h0000_8000, "R4 status lane");
        drive_src('0);
        check(32'(irq), 32'h00, "R7 line drops");
    endtask

    task automatic t_unused();
        logic [31:0] d;
        reg_write(8'h10, 32'hFFFF_0000);
        reg_read(8'h10, d); check(d, 32'h0000_8000, "R8 absent lanes");
        reg_write(8'h08, 32'hFFFF_FFFF);
        reg_read(8'h08, d); check(d, 32'h0, "R8 unused offset read");
        reg_read(8'h00, d); check(d, 32'h0000_0180, "R8 unused offset write ignored");
        reg_write(8'h20, 32'hFFFF_FFFF);
        reg_read(8'h20, d); check(d, 32'h0, "R8 absent bank");
    endtask

    task automatic t_we_low();
        logic [31:0] d;
        @(negedge clk);
        addr = 8'h00; wdata = 32'hFFFF_FFFF; we = 1'b0;
        @(negedge clk);
        addr = 8'h04;
        @(negedge clk);
        reg_read(8'h00, d); check(d, 32'h0000_0180, "R9 no write without strobe");
    endtask

    task automatic t_restore();
        logic [31:0] saved;
        logic [31:0] d;
        reg_read(8'h00, saved);
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_write(8'h04, 32'hFFFF_FFFF);
        reg_read(8'h00, d); check(d, 32'h0, "R10 all cleared");
        drive_src({16'hFFFF, 32'hFFFF_FFFF});
        check(32'(irq & 6'h0F), 32'h0, "R10 lines off when cleared");
        reg_write(8'h00, saved);
        reg_read(8'h00, d); check(d, saved, "R10 restored");
        drive_src('0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set_clear();
        t_lines();
        t_status();
        t_map();
        t_unused();
        t_we_low();
        t_restore();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule